// File: doc/BRIEF.md
# Dual-Clock Bypass Mailbox

This block carries single data words directly between two ports that run on unrelated clocks, without using the main queue memory beside it. There are two independent one-word channels, one per direction, each 18 bits wide by default. Each channel has a full flag on its writer's clock and an empty flag on its reader's clock. The two flags are kept consistent by a toggle handshake that crosses the clock boundary through multi-flop synchronizers.

Port A alone decides when bypass mode is active. It does so with its select input and its 3-bit mode code. Port B learns of the mode through an indicator that is re-timed into its own clock domain. Port B may move words only while that indicator is high. A word still pending when the indicator drops stays in the channel, and port B cannot see it until port A enters bypass mode again.

Top module: `bm_bypass_mailbox`

## Requirements
- R1: `b_bypass` rises within SYNC_STAGES+2 rising edges of `clk_b` after the first rising edge of `clk_a` at which `a_sel`=1 and `a_mode`=3'b001. It stays low while `a_sel`=0, whatever the mode code.
- R2: `b_bypass` falls within SYNC_STAGES+2 rising edges of `clk_b` after port A changes `a_mode` to 3'b000 or drops `a_sel` to 0.
- R3: A port A write (`a_en`=1, `a_wr`=1, in bypass mode) sets `a_ab_full`=1 right after that `clk_a` edge. Port A writes made while `a_ab_full`=1 are discarded.
- R4: After a port A write, `b_ab_empty` falls within SYNC_STAGES+2 rising edges of `clk_b`.
- R5: A port B read (`b_en`=1, `b_wr`=0, `b_bypass`=1, `b_ab_empty`=0) loads the word into `b_rdata` and sets `b_ab_empty`=1 right after that `clk_b` edge.
- R6: After a port B read, `a_ab_full` falls within SYNC_STAGES+2 rising edges of `clk_a`.
- R7: The B-to-A channel behaves the same way with the roles swapped. Its flags are `b_ba_full` on `clk_b` and `a_ba_empty` on `clk_a`, and port A reads it into `a_rdata`. `a_rdata` changes only on such a read.
- R8: Both channels can run at the same time. Every word arrives exactly once and in the order it was written.
- R9: Port B reads and writes are ignored while `b_bypass`=0. A pending A-to-B word stays pending, and `b_rdata` keeps its value.
- R10: Port A reads and writes are ignored unless `a_sel`=1 and `a_mode`=3'b001.
- R11: After reset, both channels are empty (`a_ab_full`=0, `b_ab_empty`=1, `b_ba_full`=0, `a_ba_empty`=1) and `b_bypass`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| a_sel | input | 1 | Port A select, active high |
| a_mode | input | 3 | Port A mode code: 3'b001 bypass, 3'b000 queue |
| a_en | input | 1 | Port A transfer enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_wdata | input | DATA_W | Port A write word |
| a_rdata | output | DATA_W | Port A output register |
| a_ab_full | output | 1 | A-to-B channel full (clk_a domain) |
| a_ba_empty | output | 1 | B-to-A channel empty (clk_a domain) |
| b_en | input | 1 | Port B transfer enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_wdata | input | DATA_W | Port B write word |
| b_rdata | output | DATA_W | Port B output register |
| b_ba_full | output | 1 | B-to-A channel full (clk_b domain) |
| b_ab_empty | output | 1 | A-to-B channel empty (clk_b domain) |
| b_bypass | output | 1 | Bypass indicator in the clk_b domain |

## Verification
The bench builds the block with DATA_W=18 and SYNC_STAGES=2. Port A runs at 20 ns and port B at 14.6 ns, so the phase between the two clocks drifts throughout the run. The two-stage depth keeps every latency bound at four edges, which lets the bench poll each flag transition within a short fixed window. The full word width lets each direction carry its own recognisable base pattern, so a lost, repeated or swapped word shows up as a data mismatch during the concurrent stream.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [2:0] {
    BM_MODE_QUEUE  = 3'b000,
    BM_MODE_BYPASS = 3'b001
  } bm_mode_e;
endpackage

// File: rtl/bm_rst_sync.sv
module bm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  always_comb begin
    st_d = {st_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/bm_chan.sv
module bm_chan #(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              w_push,
  input  logic [DATA_W-1:0] w_data,
  output logic              w_full,
  output logic              w_acc,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              r_pop,
  output logic [DATA_W-1:0] r_data,
  output logic              r_empty,
  output logic              r_acc
);
  // writer domain
  logic              w_tgl_q, w_tgl_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              ack_s;
  // reader domain
  logic              r_tgl_q, r_tgl_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              req_s;

  bm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk(wclk), .rst_n(wrst_n), .d(r_tgl_q), .q(ack_s)
  );

  bm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk(rclk), .rst_n(rrst_n), .d(w_tgl_q), .q(req_s)
  );

  assign w_full  = w_tgl_q ^ ack_s;
  assign w_acc   = w_push & ~w_full;
  assign r_empty = (req_s == r_tgl_q);
  assign r_acc   = r_pop & ~r_empty;
  assign r_data  = rdat_q;

  always_comb begin
    w_tgl_d = w_tgl_q ^ 1'b1;
    hold_d  = w_data;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      w_tgl_q <= 1'b0;
      hold_q  <= '0;
    end else if (w_acc) begin
      w_tgl_q <= w_tgl_d;
      hold_q  <= hold_d;
    end
  end

  // hold_q is stable while the word is pending, so it is sampled directly
  always_comb begin
    r_tgl_d = r_tgl_q ^ 1'b1;
    rdat_d  = hold_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      r_tgl_q <= 1'b0;
      rdat_q  <= '0;
    end else if (r_acc) begin
      r_tgl_q <= r_tgl_d;
      rdat_q  <= rdat_d;
    end
  end
endmodule

// File: rtl/bm_bypass_mailbox.sv
module bm_bypass_mailbox
  import bm_pkg::*;
#(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic [2:0]        a_mode,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_ab_full,
  output logic              a_ba_empty,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_ba_full,
  output logic              b_ab_empty,
  output logic              b_bypass
);
  logic rst_a_n_s, rst_b_n_s;
  logic a_byp_now;
  logic a_req_q, a_req_d;
  logic a_push, a_pop, b_push, b_pop;
  logic ab_w_acc, ab_r_acc, ba_w_acc, ba_r_acc;

  bm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_a (
    .clk(clk_a), .rst_in_n(rst_n), .rst_out_n(rst_a_n_s)
  );
  bm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_b (
    .clk(clk_b), .rst_in_n(rst_n), .rst_out_n(rst_b_n_s)
  );

  // mode decode, registered in port A domain before crossing
  assign a_byp_now = a_sel & (a_mode == BM_MODE_BYPASS);

  always_comb begin
    a_req_d = a_byp_now;
  end

  always_ff @(posedge clk_a or negedge rst_a_n_s) begin
    if (!rst_a_n_s) a_req_q <= 1'b0;
    else            a_req_q <= a_req_d;
  end

  bm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_byp_sync (
    .clk(clk_b), .rst_n(rst_b_n_s), .d(a_req_q), .q(b_bypass)
  );

  assign a_push = a_byp_now & a_en &  a_wr;
  assign a_pop  = a_byp_now & a_en & ~a_wr;
  assign b_push = b_bypass  & b_en &  b_wr;
  assign b_pop  = b_bypass  & b_en & ~b_wr;

  bm_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ab (
    .wclk(clk_a), .wrst_n(rst_a_n_s), .w_push(a_push), .w_data(a_wdata),
    .w_full(a_ab_full), .w_acc(ab_w_acc),
    .rclk(clk_b), .rrst_n(rst_b_n_s), .r_pop(b_pop), .r_data(b_rdata),
    .r_empty(b_ab_empty), .r_acc(ab_r_acc)
  );

  bm_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ba (
    .wclk(clk_b), .wrst_n(rst_b_n_s), .w_push(b_push), .w_data(b_wdata),
    .w_full(b_ba_full), .w_acc(ba_w_acc),
    .rclk(clk_a), .rrst_n(rst_a_n_s), .r_pop(a_pop), .r_data(a_rdata),
    .r_empty(a_ba_empty), .r_acc(ba_r_acc)
  );
endmodule

// File: rtl/bm_mailbox_chk.sv
module bm_mailbox_chk #(
  parameter int unsigned DATA_W = 18
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_a_n,
  input logic              rst_b_n,
  input logic              a_ab_full,
  input logic              a_ba_empty,
  input logic              b_ba_full,
  input logic              b_ab_empty,
  input logic              b_bypass,
  input logic [DATA_W-1:0] a_rdata,
  input logic [DATA_W-1:0] b_rdata,
  input logic              ab_w_acc,
  input logic              ab_r_acc,
  input logic              ba_w_acc,
  input logic              ba_r_acc
);
  AST_AB_FULL_AFTER_WRITE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    ab_w_acc |=> a_ab_full); // R3
  AST_AB_EMPTY_AFTER_READ: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    ab_r_acc |=> b_ab_empty); // R5
  AST_BA_FULL_AFTER_WRITE: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    ba_w_acc |=> b_ba_full); // R7
  AST_BA_EMPTY_AFTER_READ: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    ba_r_acc |=> a_ba_empty); // R7
  AST_A_RDATA_HELD: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    a_ba_empty |=> $stable(a_rdata)); // R7
  AST_B_RDATA_OFF_BYPASS: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !b_bypass |=> $stable(b_rdata)); // R9
  AST_B_NO_WRITE_OFF_BYPASS: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !b_bypass |-> !ba_w_acc); // R9
endmodule

bind bm_bypass_mailbox bm_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_a_n(rst_a_n_s), .rst_b_n(rst_b_n_s),
  .a_ab_full(a_ab_full), .a_ba_empty(a_ba_empty), .b_ba_full(b_ba_full),
  .b_ab_empty(b_ab_empty), .b_bypass(b_bypass), .a_rdata(a_rdata),
  .b_rdata(b_rdata), .ab_w_acc(ab_w_acc), .ab_r_acc(ab_r_acc),
  .ba_w_acc(ba_w_acc), .ba_r_acc(ba_r_acc)
);

// File: tb/bm_bypass_mailbox_tb_top.sv
`timescale 1ns/1ps
module bm_bypass_mailbox_tb_top;
  localparam int unsigned DW = 18;
  localparam int unsigned SS = 2;
  localparam int unsigned NWORDS = 24;
  localparam int unsigned LAT = SS + 2;
  localparam logic [DW-1:0] AB_BASE = 18'h10000;
  localparam logic [DW-1:0] BA_BASE = 18'h24000;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n;
  logic a_sel, a_en, a_wr;
  logic [2:0] a_mode;
  logic [DW-1:0] a_wdata, a_rdata;
  logic a_ab_full, a_ba_empty;
  logic b_en, b_wr;
  logic [DW-1:0] b_wdata, b_rdata;
  logic b_ba_full, b_ab_empty, b_bypass;

  int n_checks = 0;
  int n_fails  = 0;

  always #10   clk_a = ~clk_a;
  always #7.3  clk_b = ~clk_b;

  bm_bypass_mailbox #(.DATA_W(DW), .SYNC_STAGES(SS)) dut_i (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_sel(a_sel), .a_mode(a_mode), .a_en(a_en), .a_wr(a_wr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_ab_full(a_ab_full),
    .a_ba_empty(a_ba_empty), .b_en(b_en), .b_wr(b_wr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_ba_full(b_ba_full), .b_ab_empty(b_ab_empty),
    .b_bypass(b_bypass)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic wr, input logic [DW-1:0] d);
    @(negedge clk_a);
    a_en = 1'b1; a_wr = wr; a_wdata = d;
    @(posedge clk_a); #1;
    a_en = 1'b0;
  endtask

  task automatic b_op(input logic wr, input logic [DW-1:0] d);
    @(negedge clk_b);
    b_en = 1'b1; b_wr = wr; b_wdata = d;
    @(posedge clk_b); #1;
    b_en = 1'b0;
  endtask

  // poll a clk_b signal for a target value within n edges
  task automatic poll_b(input string req, ref logic sig, input logic val, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n && !seen; i++) begin
      @(posedge clk_b); #1;
      if (sig === val) seen = 1'b1;
    end
    chk(req, {31'd0, seen}, 32'd1);
  endtask

  task automatic poll_a(input string req, ref logic sig, input logic val, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n && !seen; i++) begin
      @(posedge clk_a); #1;
      if (sig === val) seen = 1'b1;
    end
    chk(req, {31'd0, seen}, 32'd1);
  endtask

  task automatic t_reset;
    a_sel = 1'b0; a_mode = 3'b000; a_en = 1'b0; a_wr = 1'b0; a_wdata = '0;
    b_en = 1'b0; b_wr = 1'b0; b_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk_a);
    rst_n = 1'b1;
    repeat (6) @(posedge clk_a);
    #1;
    chk("R11 a_ab_full",  {31'd0, a_ab_full},  32'd0);
    chk("R11 b_ab_empty", {31'd0, b_ab_empty}, 32'd1);
    chk("R11 b_ba_full",  {31'd0, b_ba_full},  32'd0);
    chk("R11 a_ba_empty", {31'd0, a_ba_empty}, 32'd1);
    chk("R11 b_bypass",   {31'd0, b_bypass},   32'd0);
  endtask

  task automatic t_enter;
    @(negedge clk_a); a_sel = 1'b0; a_mode = 3'b001;
    repeat (8) @(posedge clk_b); #1;
    chk("R1 no bypass with select low", {31'd0, b_bypass}, 32'd0);
    @(negedge clk_a); a_sel = 1'b1;
    @(posedge clk_a); #1;
    poll_b("R1 bypass set", b_bypass, 1'b1, LAT);
  endtask

  task automatic t_ab_single;
    a_op(1'b1, 18'h2A5A5);
    chk("R3 full after write", {31'd0, a_ab_full}, 32'd1);
    a_op(1'b1, 18'h11111);
    poll_b("R4 word visible", b_ab_empty, 1'b0, LAT);
    chk("R3 still full", {31'd0, a_ab_full}, 32'd1);
    b_op(1'b0, '0);
    chk("R5 b_rdata", {14'd0, b_rdata}, {14'd0, 18'h2A5A5});
    chk("R5 empty after read", {31'd0, b_ab_empty}, 32'd1);
    poll_a("R6 full released", a_ab_full, 1'b0, LAT);
    repeat (8) @(posedge clk_b); #1;
    chk("R3 blocked write not stored", {31'd0, b_ab_empty}, 32'd1);
  endtask

  task automatic t_ba_single;
    b_op(1'b1, 18'h3C3C3);
    chk("R7 ba full after write", {31'd0, b_ba_full}, 32'd1);
    poll_a("R7 ba word visible", a_ba_empty, 1'b0, LAT);
    a_op(1'b0, '0);
    chk("R7 a_rdata", {14'd0, a_rdata}, {14'd0, 18'h3C3C3});
    chk("R7 ba empty after read", {31'd0, a_ba_empty}, 32'd1);
    poll_b("R7 ba full released", b_ba_full, 1'b0, LAT);
  endtask

  task automatic t_stream;
    int a_wi = 0, a_ri = 0, b_wi = 0, b_ri = 0;
    fork
      begin : port_a_proc
        while (a_wi < NWORDS || a_ri < NWORDS) begin
          @(negedge clk_a);
          if (a_wi < NWORDS && !a_ab_full) begin
            a_en = 1'b1; a_wr = 1'b1; a_wdata = AB_BASE + DW'(a_wi);
            a_wi++;
            @(posedge clk_a); #1; a_en = 1'b0;
          end else if (a_ri < NWORDS && !a_ba_empty) begin
            a_en = 1'b1; a_wr = 1'b0;
            @(posedge clk_a); #1; a_en = 1'b0;
            chk("R8 ba stream word", {14'd0, a_rdata}, {14'd0, BA_BASE + DW'(a_ri)});
            a_ri++;
          end
        end
      end
      begin : port_b_proc
        while (b_wi < NWORDS || b_ri < NWORDS) begin
          @(negedge clk_b);
          if (b_ri < NWORDS && !b_ab_empty) begin
            b_en = 1'b1; b_wr = 1'b0;
            @(posedge clk_b); #1; b_en = 1'b0;
            chk("R8 ab stream word", {14'd0, b_rdata}, {14'd0, AB_BASE + DW'(b_ri)});
            b_ri++;
          end else if (b_wi < NWORDS && !b_ba_full) begin
            b_en = 1'b1; b_wr = 1'b1; b_wdata = BA_BASE + DW'(b_wi);
            b_wi++;
            @(posedge clk_b); #1; b_en = 1'b0;
          end
        end
      end
    join
    repeat (10) @(posedge clk_b); #1;
    chk("R8 no extra ab word", {31'd0, b_ab_empty}, 32'd1);
    chk("R8 no extra ba word", {31'd0, a_ba_empty}, 32'd1);
  endtask

  task automatic t_exit;
    logic [DW-1:0] last_b;
    last_b = b_rdata;
    a_op(1'b1, 18'h05A5A);
    poll_b("R4 pending word", b_ab_empty, 1'b0, LAT);
    @(negedge clk_a); a_mode = 3'b000;
    poll_b("R2 bypass cleared by mode", b_bypass, 1'b0, LAT + 1);
    b_op(1'b0, '0);
    chk("R9 b_rdata held", {14'd0, b_rdata}, {14'd0, last_b});
    chk("R9 word still pending", {31'd0, b_ab_empty}, 32'd0);
    b_op(1'b1, 18'h0F0F0);
    chk("R9 b write ignored", {31'd0, b_ba_full}, 32'd0);
    @(negedge clk_a); a_mode = 3'b001;
    poll_b("R1 bypass re-entered", b_bypass, 1'b1, LAT + 1);
    b_op(1'b0, '0);
    chk("R9 pending word kept", {14'd0, b_rdata}, {14'd0, 18'h05A5A});
    b_op(1'b1, 18'h0BEEF);
    poll_a("R7 ba word visible", a_ba_empty, 1'b0, LAT);
    @(negedge clk_a); a_sel = 1'b0;
    poll_b("R2 bypass cleared by select", b_bypass, 1'b0, LAT + 1);
  endtask

  task automatic t_a_ignored;
    logic [DW-1:0] last_a;
    last_a = a_rdata;
    a_op(1'b0, '0);
    chk("R10 a read ignored", {14'd0, a_rdata}, {14'd0, last_a});
    chk("R10 ba word still pending", {31'd0, a_ba_empty}, 32'd0);
    a_op(1'b1, 18'h12345);
    chk("R10 a write ignored", {31'd0, a_ab_full}, 32'd0);
    @(negedge clk_a); a_sel = 1'b1; a_mode = 3'b000;
    a_op(1'b1, 18'h12345);
    chk("R10 queue mode write ignored", {31'd0, a_ab_full}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_enter();
    t_ab_single();
    t_ba_single();
    t_stream();
    t_exit();
    t_a_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule